// File: doc/BRIEF.md
# DRAM ECC Error Status Logger

This block sits beside a two-channel DRAM controller and records the ECC error events that the controller's checkers report. Each channel can raise a correctable (single-bit) or an uncorrectable (multi-bit) error pulse. With the pulse come the location of the failing access (column, row, bank, rank) and the ECC syndrome. The block keeps a small summary status word with one sticky flag per error class. It also keeps one 64-bit error record per channel, which holds the location and syndrome of the error it captured.

Software polls the block through a simple register port. Reads return data one cycle after the request. A record is read as two 32-bit halves. Reading the lower half latches the upper half at the same moment, so a pair of reads always describes a single error. Software acknowledges errors by writing ones to the status flags. That clears the flags and the matching valid bits in every channel record, which re-arms capture. An uncorrectable error takes priority over a correctable one in the record, and a record that already holds an error keeps the first one it caught. When the controller runs with one channel only, events on the second channel are ignored.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset the status word, both channel records and `reg_rvalid_o` are all zero.
- R2: Status word (address 0, returned in `reg_rdata_o[15:0]`): bit 1 is the uncorrectable flag and bit 0 is the correctable flag. Bits 31:2 of the read data are zero. A flag is set by an error pulse of its class on any active channel.
- R3: A status write (`reg_wr_i` with address 0) clears each flag whose `reg_wdata_i` bit is 1: bit 0 clears the correctable flag and bit 1 clears the uncorrectable flag. A 0 bit leaves its flag unchanged.
- R4: Channel c's record is read at address 2+2c (bits 31:0) and 3+2c (bits 63:32). Its layout is: column 63:48, row 47:32, bank 31:29, rank 28:27, syndrome 23:16, uncorrectable-valid bit 1, correctable-valid bit 0. All other bits read zero, and at most one valid bit is set at a time.
- R5: An uncorrectable error overwrites a record that holds a correctable error. The record then carries the new fields with bit 1 = 1 and bit 0 = 0.
- R6: A correctable error on a channel whose record holds an uncorrectable error leaves the record unchanged. It still sets the correctable status flag.
- R7: A correctable error on a channel whose record already holds a correctable error leaves the record unchanged (first error kept). It still sets the status flag.
- R8: Clearing a status flag clears the matching valid bit in every channel record. The location and syndrome fields are left as they were.
- R9: When an error and a clear of its class arrive in the same cycle, the error wins: the flag stays set and the new error is captured.
- R10: With `single_chan_i` = 1, error pulses on channel 1 change neither the status word nor channel 1's record.
- R11: A read request sampled at a clock edge produces `reg_rvalid_o` = 1 and its data in the following cycle. `reg_rvalid_o` is 0 in a cycle that follows no request.
- R12: A read of a record's upper half returns the value that half had when the same channel's lower half was last read, even if the record has changed since then.
- R13: Simultaneous correctable and uncorrectable pulses on one channel capture an uncorrectable record and set both status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_chan_i | input | 1 | 1 = only channel 0 active |
| err_ce_i | input | NUM_CH | Per-channel correctable error pulse |
| err_ue_i | input | NUM_CH | Per-channel uncorrectable error pulse |
| err_col_i | input | NUM_CH*16 | Per-channel error column |
| err_row_i | input | NUM_CH*16 | Per-channel error row |
| err_bank_i | input | NUM_CH*3 | Per-channel error bank |
| err_rank_i | input | NUM_CH*2 | Per-channel error rank |
| err_synd_i | input | NUM_CH*8 | Per-channel ECC syndrome |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read request |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 2 | Write data: ones clear the matching status flags |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after the request |

## Verification
An error pulse is sampled at one clock edge. Its effect on the status word and the record is in state right after that edge, so a read issued in the next cycle sees it. Read data appears one edge after the request. The bench therefore drives every input on the falling edge. It holds a pulse for exactly one cycle and takes read data at the falling edge that follows the edge that registered the request. Same-cycle races (a clear together with an error, or both error classes together) are driven within one falling-edge window, so that both land on the same edge.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int COL_W  = 16;
  localparam int ROW_W  = 16;
  localparam int BANK_W = 3;
  localparam int RANK_W = 2;
  localparam int SYND_W = 8;

  localparam int LOG_W  = 64;
  localparam int HALF_W = LOG_W / 2;
  localparam int STAT_W = 16;
  localparam int REG_W  = 32;

  localparam int COL_LSB  = 48;
  localparam int ROW_LSB  = 32;
  localparam int BANK_LSB = 29;
  localparam int RANK_LSB = 27;
  localparam int SYND_LSB = 16;
  localparam int UE_BIT   = 1;
  localparam int CE_BIT   = 0;

  typedef struct packed {
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [RANK_W-1:0] rank;
    logic [SYND_W-1:0] synd;
  } err_fields_t;

  function automatic logic [LOG_W-1:0] pack_log(err_fields_t f, logic ue, logic ce);
    logic [LOG_W-1:0] w;
    w = '0;
    w[COL_LSB  +: COL_W]  = f.col;
    w[ROW_LSB  +: ROW_W]  = f.row;
    w[BANK_LSB +: BANK_W] = f.bank;
    w[RANK_LSB +: RANK_W] = f.rank;
    w[SYND_LSB +: SYND_W] = f.synd;
    w[UE_BIT] = ue;
    w[CE_BIT] = ce;
    return w;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(logic ue, logic ce);
    logic [STAT_W-1:0] s;
    s = '0;
    s[UE_BIT] = ue;
    s[CE_BIT] = ce;
    return s;
  endfunction
endpackage

// File: rtl/ecc_chan_log.sv
module ecc_chan_log
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              ce_i,
  input  logic              ue_i,
  input  err_fields_t       fields_i,
  input  logic              clr_ce_i,
  input  logic              clr_ue_i,
  output logic [LOG_W-1:0]  log_o
);
  err_fields_t fields_q;
  logic        ue_q, ce_q;

  // valid bits after this cycle's clear; a new error is judged against them
  logic ue_keep, ce_keep;
  logic ue_take, ce_take;

  assign ue_keep = ue_q & ~clr_ue_i;
  assign ce_keep = ce_q & ~clr_ce_i;
  assign ue_take = en_i & ue_i & ~ue_keep;
  assign ce_take = en_i & ce_i & ~ue_i & ~ue_keep & ~ce_keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fields_q <= '0;
      ue_q     <= 1'b0;
      ce_q     <= 1'b0;
    end else if (ue_take) begin
      fields_q <= fields_i;
      ue_q     <= 1'b1;
      ce_q     <= 1'b0;
    end else if (ce_take) begin
      fields_q <= fields_i;
      ue_q     <= 1'b0;
      ce_q     <= 1'b1;
    end else begin
      ue_q     <= ue_keep;
      ce_q     <= ce_keep;
    end
  end

  assign log_o = pack_log(fields_q, ue_q, ce_q);

  // R4
  one_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(log_o[UE_BIT] && log_o[CE_BIT]));
  // R5
  ue_over_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ue_i && !log_o[UE_BIT]) |=> (log_o[UE_BIT] && !log_o[CE_BIT]));
  // R6
  ue_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_o[UE_BIT] && !clr_ue_i) |=> $stable(log_o));
  // R7
  first_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_o[CE_BIT] && !clr_ce_i && !(en_i && ue_i)) |=> $stable(log_o));
  // R10
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_ce_i && !clr_ue_i) |=> $stable(log_o));
endmodule

// File: rtl/ecc_reg_port.sv
module ecc_reg_port
  import ecc_log_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [STAT_W-1:0]       status_i,
  input  logic [NUM_CH*LOG_W-1:0] logs_i,
  output logic [REG_W-1:0]        rdata_o,
  output logic                    rvalid_o
);
  logic [NUM_CH-1:0][HALF_W-1:0] snap_q;
  logic [REG_W-1:0]              rd_next;

  function automatic logic [ADDR_W-1:0] lo_addr(int c);
    return ADDR_W'(2 + 2 * c);
  endfunction

  function automatic logic [ADDR_W-1:0] hi_addr(int c);
    return ADDR_W'(3 + 2 * c);
  endfunction

  // upper half is latched whenever the lower half of the same record is read
  for (genvar c = 0; c < NUM_CH; c++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rst_n)
        snap_q[c] <= '0;
      else if (rd_i && addr_i == lo_addr(c))
        snap_q[c] <= logs_i[c*LOG_W + HALF_W +: HALF_W];
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr_i == '0)
      rd_next = REG_W'(status_i);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == lo_addr(c)) rd_next = logs_i[c*LOG_W +: HALF_W];
      if (addr_i == hi_addr(c)) rd_next = snap_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_next;
    end
  end

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rvalid_o);
  // R11
  no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !rvalid_o);
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     single_chan_i,
  input  logic [NUM_CH-1:0]        err_ce_i,
  input  logic [NUM_CH-1:0]        err_ue_i,
  input  logic [NUM_CH*COL_W-1:0]  err_col_i,
  input  logic [NUM_CH*ROW_W-1:0]  err_row_i,
  input  logic [NUM_CH*BANK_W-1:0] err_bank_i,
  input  logic [NUM_CH*RANK_W-1:0] err_rank_i,
  input  logic [NUM_CH*SYND_W-1:0] err_synd_i,
  input  logic                     reg_wr_i,
  input  logic                     reg_rd_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [1:0]               reg_wdata_i,
  output logic [REG_W-1:0]         reg_rdata_o,
  output logic                     reg_rvalid_o
);
  logic [NUM_CH-1:0]        chan_en;
  logic [NUM_CH*LOG_W-1:0]  logs;
  logic                     clr_ce, clr_ue;
  logic                     set_ce, set_ue;
  logic                     stat_ue_q, stat_ce_q;
  logic [STAT_W-1:0]        status;

  assign clr_ce = reg_wr_i && reg_addr_i == '0 && reg_wdata_i[CE_BIT];
  assign clr_ue = reg_wr_i && reg_addr_i == '0 && reg_wdata_i[UE_BIT];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    err_fields_t f;
    if (c == 0) begin : g_first
      assign chan_en[c] = 1'b1;
    end else begin : g_other
      assign chan_en[c] = ~single_chan_i;
    end
    assign f.col  = err_col_i [c*COL_W  +: COL_W];
    assign f.row  = err_row_i [c*ROW_W  +: ROW_W];
    assign f.bank = err_bank_i[c*BANK_W +: BANK_W];
    assign f.rank = err_rank_i[c*RANK_W +: RANK_W];
    assign f.synd = err_synd_i[c*SYND_W +: SYND_W];

    ecc_chan_log i_chan_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (chan_en[c]),
      .ce_i     (err_ce_i[c]),
      .ue_i     (err_ue_i[c]),
      .fields_i (f),
      .clr_ce_i (clr_ce),
      .clr_ue_i (clr_ue),
      .log_o    (logs[c*LOG_W +: LOG_W])
    );
  end

  assign set_ce = |(err_ce_i & chan_en);
  assign set_ue = |(err_ue_i & chan_en);

  // set beats clear when both land on one edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_ce_q <= 1'b0;
      stat_ue_q <= 1'b0;
    end else begin
      stat_ce_q <= (stat_ce_q & ~clr_ce) | set_ce;
      stat_ue_q <= (stat_ue_q & ~clr_ue) | set_ue;
    end
  end

  assign status = pack_status(stat_ue_q, stat_ce_q);

  ecc_reg_port #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_reg_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (reg_rd_i),
    .addr_i   (reg_addr_i),
    .status_i (status),
    .logs_i   (logs),
    .rdata_o  (reg_rdata_o),
    .rvalid_o (reg_rvalid_o)
  );

  // R9
  set_wins_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ce |=> stat_ce_q);
  // R9
  set_wins_ue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ue |=> stat_ue_q);
  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_ce && !clr_ue && !set_ce && !set_ue) |=> $stable(status));
  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ue && !set_ue) |=> !stat_ue_q);
endmodule

// File: tb/test_ecc_err_logger.sv
module test_ecc_err_logger;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic single_chan = 1'b0;
  logic [NCH-1:0] ce = '0, ue = '0;
  logic [NCH*16-1:0] col = '0, row = '0;
  logic [NCH*3-1:0] bank = '0;
  logic [NCH*2-1:0] rank = '0;
  logic [NCH*8-1:0] synd = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [1:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_logger i_ecc_err_logger (
    .clk(clk), .rst_n(rst_n), .single_chan_i(single_chan),
    .err_ce_i(ce), .err_ue_i(ue), .err_col_i(col), .err_row_i(row),
    .err_bank_i(bank), .err_rank_i(rank), .err_synd_i(synd),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_rvalid_o(rvalid)
  );

  function automatic logic [63:0] model_log(int c, int r, int b, int k, int s, bit u, bit e);
    return 64'(c) * 64'h1_0000_0000_0000 + 64'(r) * 64'h1_0000_0000
         + 64'(b) * 64'h2000_0000 + 64'(k) * 64'h800_0000
         + 64'(s) * 64'h1_0000 + 64'(u) * 2 + 64'(e);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(int ch, bit e, bit u, int c, int r, int b, int k, int s, bit w, logic [1:0] m);
    @(negedge clk);
    ce[ch] = e; ue[ch] = u;
    col[ch*16 +: 16] = 16'(c); row[ch*16 +: 16] = 16'(r);
    bank[ch*3 +: 3] = 3'(b); rank[ch*2 +: 2] = 2'(k); synd[ch*8 +: 8] = 8'(s);
    wr = w; wdata = m; addr = '0;
    @(negedge clk);
    ce = '0; ue = '0; wr = 1'b0; wdata = '0;
  endtask

  task automatic inj(int ch, bit e, bit u, int c, int r, int b, int k, int s);
    drive(ch, e, u, c, r, b, k, s, 1'b0, 2'b00);
  endtask

  task automatic wclr(logic [1:0] m);
    @(negedge clk);
    wr = 1'b1; addr = '0; wdata = m;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rdreg(int a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = 3'(a);
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic rdlog(int ch, output logic [63:0] d);
    logic [31:0] lo, hi;
    rdreg(2 + 2*ch, lo);
    rdreg(3 + 2*ch, hi);
    d = {hi, lo};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] lg, prev;
    repeat (3) @(negedge clk);
    chk("R1 rvalid", 64'(rvalid), 0);
    rst_n = 1'b1;
    rdreg(0, d);  chk("R1 status", 64'(d), 0);
    rdlog(0, lg); chk("R1 log0", lg, 0);
    rdlog(1, lg); chk("R1 log1", lg, 0);

    // R2 R4 R13 sweep: channel x error kind x field pattern
    for (int ch = 0; ch < NCH; ch++)
      for (int kind = 0; kind < 3; kind++)
        for (int p = 0; p < 4; p++) begin
          int c = 16'h1111 * (p + 1) + ch;
          int r = 16'hA5A5 ^ (p << 4);
          int b = (p + ch + kind) % 8;
          int k = (p + kind) % 4;
          int s = (8'h3C + p * 17) % 256;
          bit e = (kind != 1);
          bit u = (kind != 0);
          wclr(2'b11);
          inj(ch, e, u, c, r, b, k, s);
          rdreg(0, d);
          chk(kind == 2 ? "R13 status" : "R2 status", 64'(d), 64'(u) * 2 + 64'(e));
          rdlog(ch, lg);
          chk(kind == 2 ? "R13 log" : "R4 log", lg, model_log(c, r, b, k, s, u, !u));
        end

    // R11 latency
    @(negedge clk); rd = 1'b1; addr = 3'd0;
    @(negedge clk); rd = 1'b0;
    chk("R11 rvalid high", 64'(rvalid), 1);
    @(negedge clk);
    chk("R11 rvalid low", 64'(rvalid), 0);

    // R3 write-one-to-clear
    wclr(2'b11);
    inj(0, 1, 1, 1, 2, 3, 1, 5);
    wclr(2'b00); rdreg(0, d); chk("R3 zero write", 64'(d), 3);
    wclr(2'b10); rdreg(0, d); chk("R3 clear ue", 64'(d), 1);
    wclr(2'b01); rdreg(0, d); chk("R3 clear ce", 64'(d), 0);

    // R8 valid bits cleared, fields kept
    inj(1, 1, 0, 16'h7777, 16'h0102, 6, 2, 8'h99);
    wclr(2'b01);
    rdlog(1, lg); chk("R8 ce valid cleared", lg, model_log(16'h7777, 16'h0102, 6, 2, 8'h99, 0, 0));

    // R5 UE overwrites CE
    wclr(2'b11);
    inj(0, 1, 0, 16'h1000, 16'h2000, 1, 1, 8'h11);
    inj(0, 0, 1, 16'h3000, 16'h4000, 2, 3, 8'h22);
    rdlog(0, lg); chk("R5 ue replaces ce", lg, model_log(16'h3000, 16'h4000, 2, 3, 8'h22, 1, 0));
    rdreg(0, d);  chk("R5 status", 64'(d), 3);

    // R6 CE blocked by UE
    wclr(2'b11);
    inj(0, 0, 1, 16'hAAAA, 16'hBBBB, 5, 0, 8'h33);
    inj(0, 1, 0, 16'hCCCC, 16'hDDDD, 4, 1, 8'h44);
    rdlog(0, lg); chk("R6 log frozen", lg, model_log(16'hAAAA, 16'hBBBB, 5, 0, 8'h33, 1, 0));
    rdreg(0, d);  chk("R6 status", 64'(d), 3);
    inj(0, 0, 1, 16'hEEEE, 16'h1234, 7, 2, 8'h55);
    rdlog(0, lg); chk("R6 second ue ignored", lg, model_log(16'hAAAA, 16'hBBBB, 5, 0, 8'h33, 1, 0));

    // R7 first CE kept
    wclr(2'b11);
    inj(1, 1, 0, 16'h0F0F, 16'hF0F0, 3, 2, 8'h66);
    inj(1, 1, 0, 16'h1F1F, 16'hE0E0, 1, 1, 8'h77);
    rdlog(1, lg); chk("R7 first kept", lg, model_log(16'h0F0F, 16'hF0F0, 3, 2, 8'h66, 0, 1));
    rdreg(0, d);  chk("R7 status", 64'(d), 1);

    // R9 new error wins over same-cycle clear
    drive(1, 1, 0, 16'h2F2F, 16'hD0D0, 2, 3, 8'h88, 1'b1, 2'b01);
    rdreg(0, d);  chk("R9 ce flag kept", 64'(d), 1);
    rdlog(1, lg); chk("R9 new ce logged", lg, model_log(16'h2F2F, 16'hD0D0, 2, 3, 8'h88, 0, 1));
    wclr(2'b11);
    inj(0, 0, 1, 16'h0001, 16'h0002, 1, 0, 8'h01);
    drive(0, 0, 1, 16'h0003, 16'h0004, 2, 1, 8'h02, 1'b1, 2'b10);
    rdreg(0, d);  chk("R9 ue flag kept", 64'(d), 2);
    rdlog(0, lg); chk("R9 new ue logged", lg, model_log(16'h0003, 16'h0004, 2, 1, 8'h02, 1, 0));

    // R10 single-channel mode
    wclr(2'b11);
    rdlog(1, prev);
    single_chan = 1'b1;
    inj(1, 1, 1, 16'h5555, 16'h6666, 7, 3, 8'hEE);
    rdreg(0, d);  chk("R10 status untouched", 64'(d), 0);
    rdlog(1, lg); chk("R10 log1 untouched", lg, prev);
    inj(0, 1, 0, 16'h4321, 16'h8765, 0, 2, 8'h0D);
    rdlog(0, lg); chk("R10 ch0 still active", lg, model_log(16'h4321, 16'h8765, 0, 2, 8'h0D, 0, 1));
    single_chan = 1'b0;

    // R12 upper half latched at lower-half read
    wclr(2'b11);
    inj(0, 1, 0, 16'hABCD, 16'h1357, 3, 1, 8'h42);
    rdreg(2, d);
    inj(0, 0, 1, 16'hDCBA, 16'h2468, 4, 2, 8'h24);
    rdreg(3, d);
    chk("R12 latched high", 64'(d), model_log(16'hABCD, 16'h1357, 3, 1, 8'h42, 0, 1) >> 32);
    rdlog(0, lg); chk("R12 fresh pair", lg, model_log(16'hDCBA, 16'h2468, 4, 2, 8'h24, 1, 0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule